// File: doc/BRIEF.md
# Interlock and Supply Fault Supervisor

This block gathers the safety inputs of a transmitter controller and turns them into shutdown and inhibit signals. Three interlock sources (door, external equipment, interlock-string supply), two classes of fault, an operator off command and a regulator-good status enter asynchronously. Each passes through a two-flop synchronizer before any output depends on it. From these the block produces an interlock-fault flag, a fault-induced off command, a main-contactor inhibit and a clear for the turn-on one-shot.

The block also holds the power-level setting. Commands arrive as a word qualified by a strobe, synchronous to the block clock. A command whose top bit is set carries a new level in its low bits. When that level differs from the stored one, the block loads it and emits a one-cycle level-change pulse. A supply failure, seen as regulator-good going low, takes effect across the block in the same cycle. It disables command decode, blocks level loading, forces the stored level to zero, inhibits the main contactor and clears the turn-on one-shot.

Top module: `fault_supervisor`

## Requirements
- R1: `intlk_fault` is high exactly when, two clock edges earlier, at least one of `door_open`, `ext_unsafe` or `string_lost` was high. Each of these inputs takes two rising edges to reach the outputs.
- R2: `fault_off` is high exactly when the synchronized interlock-fault condition or the synchronized `fault_c1` is high.
- R3: `contactor_inhibit` is high when the synchronized `fault_c1`, `fault_c2` or `off_cmd` is high.
- R4: A supply fault, meaning synchronized `reg_good` low, drives `contactor_inhibit` and `oneshot_clear` high.
- R5: `decode_en` is high exactly when no supply fault is present. With `decode_en` low, no command is acted on.
- R6: On a rising edge where `cmd_strobe` is high, `decode_en` is high and `cmd_word[LVL_W]` is 1, `power_level` takes `cmd_word[LVL_W-1:0]` after that edge.
- R7: `level_change` is high for the one cycle after an edge that loaded a level different from the stored one. Otherwise it is low, including when a load command repeats the stored value.
- R8: While a supply fault is present, `power_level` reads zero after the next edge and `level_change` stays low, whatever the command inputs do.
- R9: A strobed command with `cmd_word[LVL_W]` equal to 0 leaves `power_level` unchanged and produces no `level_change`.
- R10: During and right after reset, synchronizers read as no fault, `reg_good` reads low and `power_level` is zero. The outputs therefore come up with inhibit, one-shot clear and zero level asserted, and with decode disabled.
- R11: `oneshot_clear` is high exactly when `contactor_inhibit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| door_open | input | 1 | An interlocked door is open (async) |
| ext_unsafe | input | 1 | External interlocked equipment unsafe (async) |
| string_lost | input | 1 | Interlock-string supply lost (async) |
| fault_c1 | input | 1 | Class-1 fault (async) |
| fault_c2 | input | 1 | Class-2 fault (async) |
| off_cmd | input | 1 | Operator off command (async) |
| reg_good | input | 1 | Low-voltage regulators healthy (async) |
| cmd_strobe | input | 1 | Command word valid this cycle |
| cmd_word | input | LVL_W+1 | Bit LVL_W = load-level opcode, low bits = level |
| intlk_fault | output | 1 | Interlock fault flag |
| fault_off | output | 1 | Fault-induced off command |
| contactor_inhibit | output | 1 | Main-contactor inhibit |
| oneshot_clear | output | 1 | Clear for the turn-on one-shot |
| decode_en | output | 1 | Command decode enabled |
| power_level | output | LVL_W | Stored power level |
| level_change | output | 1 | One-cycle pulse on a changed level |

## Verification
All 128 combinations of the seven asynchronous inputs are applied and held. Each output is compared with its Boolean formula, which separates the OR terms of the interlock flag, the class-1 fault path into the off command and the inhibit, and the supply-fault term that only the inhibit and decode enable see. A latency probe confirms that nothing moves after one edge and the outputs settle after two. Every command word is strobed against every stored level. This separates real changes from repeated values and from non-load opcodes. The same strobes repeated under a supply fault show that loading is blocked and the level is zeroed.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int LVL_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             door_open,
  input  logic             ext_unsafe,
  input  logic             string_lost,
  input  logic             fault_c1,
  input  logic             fault_c2,
  input  logic             off_cmd,
  input  logic             reg_good,
  input  logic             cmd_strobe,
  input  logic [LVL_W:0]   cmd_word,
  output logic             intlk_fault,
  output logic             fault_off,
  output logic             contactor_inhibit,
  output logic             oneshot_clear,
  output logic             decode_en,
  output logic [LVL_W-1:0] power_level,
  output logic             level_change
);
  localparam int NIN = 7;
  localparam logic [NIN-1:0] RST_VAL = '0;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync [SYNC_N];
  logic [NIN-1:0] s;

  assign raw = {reg_good, off_cmd, fault_c2, fault_c1, string_lost, ext_unsafe, door_open};

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync[g] <= RST_VAL;
        else        sync[g] <= (g == 0) ? raw : sync[(g == 0) ? 0 : g-1];
    end
  endgenerate

  assign s = sync[SYNC_N-1];

  logic supply_fault, inhibit_faults;
  assign supply_fault      = ~s[6];
  assign intlk_fault       = s[0] | s[1] | s[2];
  assign fault_off         = intlk_fault | s[3];
  assign inhibit_faults    = s[3] | s[4] | s[5];
  assign contactor_inhibit = inhibit_faults | supply_fault;
  assign oneshot_clear     = supply_fault | inhibit_faults;
  assign decode_en         = ~supply_fault;

  logic             load_cmd;
  logic [LVL_W-1:0] new_lvl;
  assign load_cmd = cmd_strobe & decode_en & cmd_word[LVL_W];
  assign new_lvl  = cmd_word[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      power_level  <= '0;
      level_change <= 1'b0;
    end else if (supply_fault) begin
      power_level  <= '0;
      level_change <= 1'b0;
    end else if (load_cmd && new_lvl != power_level) begin
      power_level  <= new_lvl;
      level_change <= 1'b1;
    end else begin
      level_change <= 1'b0;
    end

  p_supply_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en |=> (power_level == '0 && !level_change));
  p_change_differs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level_change |-> power_level != $past(power_level));
  p_hold_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_en && !(cmd_strobe && cmd_word[LVL_W])) |=> $stable(power_level));
  p_inhibit_on_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en |-> (contactor_inhibit && oneshot_clear));
  p_off_implies_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_off && !intlk_fault) |-> contactor_inhibit);
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int LVL_W = 4;
  logic clk = 0, rst_n = 0;
  logic door_open = 0, ext_unsafe = 0, string_lost = 0, fault_c1 = 0, fault_c2 = 0, off_cmd = 0, reg_good = 0;
  logic cmd_strobe = 0;
  logic [LVL_W:0] cmd_word = '0;
  logic intlk_fault, fault_off, contactor_inhibit, oneshot_clear, decode_en, level_change;
  logic [LVL_W-1:0] power_level;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_supervisor #(.LVL_W(LVL_W), .SYNC_N(2)) i_fault_supervisor (
    .clk, .rst_n, .door_open, .ext_unsafe, .string_lost, .fault_c1, .fault_c2,
    .off_cmd, .reg_good, .cmd_strobe, .cmd_word, .intlk_fault, .fault_off,
    .contactor_inhibit, .oneshot_clear, .decode_en, .power_level, .level_change);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_in(input logic [6:0] v);
    {reg_good, off_cmd, fault_c2, fault_c1, string_lost, ext_unsafe, door_open} = v;
  endtask

  task automatic strobe(input logic [LVL_W:0] w);
    cmd_strobe = 1; cmd_word = w; tick(); cmd_strobe = 0;
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(); tick();
    // R10 reset state
    chk(contactor_inhibit == 1, "R10 inhibit", contactor_inhibit, 1);
    chk(oneshot_clear == 1, "R10 clear", oneshot_clear, 1);
    chk(decode_en == 0, "R10 decode", decode_en, 0);
    chk(power_level == 0, "R10 level", power_level, 0);
    chk(intlk_fault == 0 && fault_off == 0, "R10 intlk", {intlk_fault, fault_off}, 0);
    rst_n = 1;

    // R1 latency: interlock input takes two edges
    reg_good = 1; tick(); tick(); tick();
    door_open = 1; tick();
    chk(intlk_fault == 0, "R1 one edge", intlk_fault, 0);
    tick();
    chk(intlk_fault == 1, "R1 two edges", intlk_fault, 1);

    // R1..R5, R11 exhaustive sweep
    for (int v = 0; v < 128; v++) begin
      logic il, c1, c2, off, good, ei, eo, einh;
      set_in(v[6:0]); tick(); tick(); tick();
      il = v[0] | v[1] | v[2]; c1 = v[3]; c2 = v[4]; off = v[5]; good = v[6];
      ei = il; eo = il | c1; einh = c1 | c2 | off | ~good;
      chk(intlk_fault == ei, "R1 flag", intlk_fault, ei);
      chk(fault_off == eo, "R2 off", fault_off, eo);
      chk(contactor_inhibit == einh, good ? "R3 inhibit" : "R4 inhibit", contactor_inhibit, einh);
      chk(oneshot_clear == einh, "R11 clear", oneshot_clear, einh);
      chk(decode_en == good, "R5 decode", decode_en, good);
    end

    // R6, R7, R9: all words against all stored levels
    set_in(7'b1000000); tick(); tick(); tick();
    for (int l = 0; l < 16; l++) begin
      for (int w = 0; w < 32; w++) begin
        logic [3:0] el; logic ec;
        strobe(5'(16 + l));
        strobe(5'(w));
        el = w[4] ? w[3:0] : 4'(l);
        ec = w[4] && (w[3:0] != l);
        chk(power_level == el, w[4] ? "R6 load" : "R9 ignore", power_level, el);
        chk(level_change == ec, w[4] ? "R7 pulse" : "R9 no pulse", level_change, ec);
        tick();
        chk(level_change == 0, "R7 one cycle", level_change, 0);
      end
    end

    // R8, R5: supply fault zeroes and blocks
    strobe(5'h1A);
    chk(power_level == 10, "R6 preload", power_level, 10);
    reg_good = 0; tick(); tick();
    chk(decode_en == 0, "R5 off", decode_en, 0);
    tick();
    chk(power_level == 0, "R8 zero", power_level, 0);
    for (int w = 0; w < 32; w++) begin
      strobe(5'(w));
      chk(power_level == 0, "R8 blocked", power_level, 0);
      chk(level_change == 0, "R8 no pulse", level_change, 0);
    end
    reg_good = 1; tick(); tick(); tick();
    strobe(5'h15);
    chk(power_level == 5 && level_change == 1, "R6 recover", power_level, 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule